// File: doc/BRIEF.md
# Host-to-Peer Mailbox FIFO

This block lets a host CPU and a peer processor exchange word-sized messages through two one-way queues. The inbound queue is loaded by the peer through a push handshake and emptied by the host through a small register interface. The outbound queue is loaded by host register writes and emptied by the peer through a pop handshake. Each inbound word carries a small sender identity that the host can inspect next to the word itself.

The host reads the oldest inbound word either destructively or as a non-destructive peek. Each queue has a status word that packs a full flag, an empty flag and the current fill count. Host software checks the outbound status for the full flag before writing. A level interrupt, gated by an enable bit in the configuration register, stays asserted while the inbound queue holds data.

Host reads are combinational from registered state: `host_rdata` is valid in the same cycle as `host_rd`, and any pop happens at the following clock edge. The peer sees the head of the outbound queue on `out_pop_data` whenever `out_empty` is low.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, both status words read 0x40000000, the configuration register reads 0 and `host_irq` is low.
- R2: A status word has bit 31 set when the queue is full, bit 30 set when it is empty, and the entry count in its low bits. With depth 8, a full queue reads 0x80000008 and a partly filled one reads 0x00000001 to 0x00000007.
- R3: A peer push stores the data word and its sender identity at the tail of the inbound queue, and words leave in the order they arrived. `in_full` is high while the inbound queue is full, and a push in that state is dropped.
- R4: A host read of offset 0x00 returns the oldest inbound word and removes it at the next clock edge.
- R5: A host read of offset 0x10 returns the oldest inbound word and leaves the queue and its count unchanged.
- R6: A host read of offset 0x14 returns the sender identity of the oldest inbound word in bits [1:0], with zeros above it. It reads 0 when the inbound queue is empty.
- R7: A host write to offset 0x20 appends the write data to the outbound queue. The peer sees the head on `out_pop_data` and removes it with `out_pop`, and words leave in order. `out_pop_data` reads 0 when the queue is empty. A write to a full outbound queue is dropped and sets a sticky overflow flag, bit 29 of the outbound status at 0x38, which only reset clears.
- R8: Bit 0 of the configuration register at 0x1C is writable and can be read back. `host_irq` equals that bit ANDed with "inbound not empty", so it drops in the cycle after the last word is popped.
- R9: A host read of offset 0x00 while the inbound queue is empty returns 0 and leaves the queue empty.
- R10: Unmapped offsets read as 0. Host writes to any offset other than 0x1C and 0x20 have no effect on either queue or on any status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W (8) | Host register byte offset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DATA_W (32) | Host write data |
| host_rdata | output | DATA_W (32) | Host read data, combinational |
| host_irq | output | 1 | Level interrupt: inbound data present and enabled |
| in_push | input | 1 | Peer push strobe for the inbound queue |
| in_push_data | input | DATA_W (32) | Peer data word |
| in_push_id | input | ID_W (2) | Peer sender identity |
| in_full | output | 1 | Inbound queue full |
| out_pop | input | 1 | Peer pop strobe for the outbound queue |
| out_pop_data | output | DATA_W (32) | Head of the outbound queue |
| out_empty | output | 1 | Outbound queue empty |

## Verification
The bench builds the block with its default parameters: depth 8, 32-bit words, a 2-bit sender identity and 8-bit offsets. With these values the status words can be compared against fixed codes such as 0x80000008, and the pointers wrap through the power-of-two path. The directed tasks fill each queue to capacity and push past it. They walk the sender identity through all four values while draining, and they check the interrupt level and the sticky overflow flag before and after each edge that should change them.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

   // Host register byte offsets (software decodes these).
   localparam logic [7:0] OFS_IN_POP  = 8'h00;
   localparam logic [7:0] OFS_IN_PEEK = 8'h10;
   localparam logic [7:0] OFS_IN_ID   = 8'h14;
   localparam logic [7:0] OFS_IN_STAT = 8'h18;
   localparam logic [7:0] OFS_CFG     = 8'h1C;
   localparam logic [7:0] OFS_OUT_WR  = 8'h20;
   localparam logic [7:0] OFS_OUT_STAT= 8'h38;

   // Status word flag positions, counted down from the top bit.
   localparam int unsigned STAT_FULL_FROM_TOP  = 1;
   localparam int unsigned STAT_EMPTY_FROM_TOP = 2;
   localparam int unsigned STAT_OVF_FROM_TOP   = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_IN_POP,
      SEL_IN_PEEK,
      SEL_IN_ID,
      SEL_IN_STAT,
      SEL_CFG,
      SEL_OUT_WR,
      SEL_OUT_STAT
   } mbox_sel_e;

endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo #(
   parameter int unsigned W     = 34,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ipc_mbox_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("ipc_mbox_fifo: W must be at least 1");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign count   = cnt_q;
   assign head    = empty ? '0 : mem[rd_ptr];

   // Pointer wrap: free for power-of-two depths, explicit compare otherwise.
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/ipc_mbox_host_regs.sv
module ipc_mbox_host_regs
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 2,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] in_head,
   input  logic [ID_W-1:0]   in_head_id,
   input  logic [CNT_W-1:0]  in_count,
   input  logic              in_full,
   input  logic              in_empty,
   input  logic [CNT_W-1:0]  out_count,
   input  logic              out_full,
   input  logic              out_empty,
   output logic              in_pop,
   output logic              out_push,
   output logic              irq_en,
   output logic              ovf_sticky
);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ipc_mbox_host_regs: ADDR_W must reach offset 0x38");
   end
   if (CNT_W + STAT_OVF_FROM_TOP > DATA_W) begin : g_bad_stat
      $error("ipc_mbox_host_regs: count field collides with status flags");
   end
   if (ID_W > DATA_W) begin : g_bad_id
      $error("ipc_mbox_host_regs: ID_W wider than the data word");
   end

   mbox_sel_e sel;

   always_comb begin
      if      (addr == ADDR_W'(OFS_IN_POP))   sel = SEL_IN_POP;
      else if (addr == ADDR_W'(OFS_IN_PEEK))  sel = SEL_IN_PEEK;
      else if (addr == ADDR_W'(OFS_IN_ID))    sel = SEL_IN_ID;
      else if (addr == ADDR_W'(OFS_IN_STAT))  sel = SEL_IN_STAT;
      else if (addr == ADDR_W'(OFS_CFG))      sel = SEL_CFG;
      else if (addr == ADDR_W'(OFS_OUT_WR))   sel = SEL_OUT_WR;
      else if (addr == ADDR_W'(OFS_OUT_STAT)) sel = SEL_OUT_STAT;
      else                                    sel = SEL_NONE;
   end

   function automatic logic [DATA_W-1:0] pack_status(
      input logic f, input logic e, input logic o, input logic [CNT_W-1:0] c);
      logic [DATA_W-1:0] s;
      s = '0;
      s[DATA_W-STAT_FULL_FROM_TOP]  = f;
      s[DATA_W-STAT_EMPTY_FROM_TOP] = e;
      s[DATA_W-STAT_OVF_FROM_TOP]   = o;
      s[CNT_W-1:0]                  = c;
      return s;
   endfunction

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (sel)
            SEL_IN_POP,
            SEL_IN_PEEK:  rdata = in_head;
            SEL_IN_ID:    rdata = DATA_W'(in_head_id);
            SEL_IN_STAT:  rdata = pack_status(in_full, in_empty, 1'b0, in_count);
            SEL_CFG:      rdata = DATA_W'(irq_en);
            SEL_OUT_STAT: rdata = pack_status(out_full, out_empty, ovf_sticky, out_count);
            default:      rdata = '0;
         endcase
      end
   end

   assign in_pop   = rd & (sel == SEL_IN_POP) & ~in_empty;
   assign out_push = wr & (sel == SEL_OUT_WR) & ~out_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en     <= 1'b0;
         ovf_sticky <= 1'b0;
      end else begin
         if (wr && sel == SEL_CFG) irq_en <= wdata[0];
         if (wr && sel == SEL_OUT_WR && out_full) ovf_sticky <= 1'b1;
      end
   end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 2,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_irq,
   input  logic              in_push,
   input  logic [DATA_W-1:0] in_push_data,
   input  logic [ID_W-1:0]   in_push_id,
   output logic              in_full,
   input  logic              out_pop,
   output logic [DATA_W-1:0] out_pop_data,
   output logic              out_empty
);

   localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
   localparam int unsigned IN_W   = DATA_W + ID_W;

   if (ID_W < 1) begin : g_bad_id
      $error("ipc_mailbox: ID_W must be at least 1");
   end

   logic [IN_W-1:0]   in_head_raw;
   logic [CNT_W-1:0]  in_count, out_count;
   logic              in_empty, out_full;
   logic              in_pop, out_push, irq_en, ovf_sticky;

   ipc_mbox_fifo #(.W(IN_W), .DEPTH(DEPTH)) u_in_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_push),
      .push_data ({in_push_id, in_push_data}),
      .pop       (in_pop),
      .head      (in_head_raw),
      .count     (in_count),
      .full      (in_full),
      .empty     (in_empty)
   );

   ipc_mbox_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_out_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (out_push),
      .push_data (host_wdata),
      .pop       (out_pop),
      .head      (out_pop_data),
      .count     (out_count),
      .full      (out_full),
      .empty     (out_empty)
   );

   ipc_mbox_host_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (host_addr),
      .rd         (host_rd),
      .wr         (host_wr),
      .wdata      (host_wdata),
      .rdata      (host_rdata),
      .in_head    (in_head_raw[DATA_W-1:0]),
      .in_head_id (in_head_raw[IN_W-1:DATA_W]),
      .in_count   (in_count),
      .in_full    (in_full),
      .in_empty   (in_empty),
      .out_count  (out_count),
      .out_full   (out_full),
      .out_empty  (out_empty),
      .in_pop     (in_pop),
      .out_push   (out_push),
      .irq_en     (irq_en),
      .ovf_sticky (ovf_sticky)
   );

   assign host_irq = irq_en & ~in_empty;

endmodule

// File: rtl/ipc_mailbox_checker.sv
module ipc_mailbox_checker
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_rd,
   input logic              host_wr,
   input logic              in_push,
   input logic              out_pop,
   input logic              host_irq,
   input logic [CNT_W-1:0]  in_count,
   input logic [CNT_W-1:0]  out_count,
   input logic              in_full,
   input logic              out_full,
   input logic              in_empty,
   input logic              ovf_sticky
);

   logic rd_pop, rd_peek, wr_out;
   assign rd_pop  = host_rd && host_addr == ADDR_W'(OFS_IN_POP);
   assign rd_peek = host_rd && host_addr == ADDR_W'(OFS_IN_PEEK);
   assign wr_out  = host_wr && host_addr == ADDR_W'(OFS_OUT_WR);

   AST_FULL_MEANS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      in_full |-> in_count == CNT_W'(DEPTH));                              // R2
   AST_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_push && in_full && !rd_pop) |=> in_count == CNT_W'(DEPTH));      // R3
   AST_POP_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && !in_empty && !in_push) |=> in_count == $past(in_count) - CNT_W'(1)); // R4
   AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_peek && !in_push) |=> $stable(in_count));                        // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_out && out_full && !out_pop) |=> (out_count == CNT_W'(DEPTH)) && ovf_sticky); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_sticky |=> ovf_sticky);                                          // R7
   AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> in_count != '0);                                        // R8
   AST_EMPTY_READ_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && in_empty && !in_push) |=> in_count == '0);                // R9

endmodule

bind ipc_mailbox ipc_mailbox_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_rd    (host_rd),
   .host_wr    (host_wr),
   .in_push    (in_push),
   .out_pop    (out_pop),
   .host_irq   (host_irq),
   .in_count   (in_count),
   .out_count  (out_count),
   .in_full    (in_full),
   .out_full   (out_full),
   .in_empty   (in_empty),
   .ovf_sticky (ovf_sticky)
);

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  host_addr = '0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_irq;
   logic        in_push = 1'b0;
   logic [31:0] in_push_data = '0;
   logic [1:0]  in_push_id = '0;
   logic        in_full;
   logic        out_pop = 1'b0;
   logic [31:0] out_pop_data;
   logic        out_empty;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_mailbox u_ipc_mailbox (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
      .in_push(in_push), .in_push_data(in_push_data), .in_push_id(in_push_id),
      .in_full(in_full),
      .out_pop(out_pop), .out_pop_data(out_pop_data), .out_empty(out_empty)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic host_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic host_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic peer_push(input logic [31:0] d, input logic [1:0] id);
      @(negedge clk);
      in_push = 1'b1; in_push_data = d; in_push_id = id;
      @(negedge clk);
      in_push = 1'b0;
   endtask

   task automatic peer_pop(output logic [31:0] d);
      @(negedge clk);
      out_pop = 1'b1;
      #1 d = out_pop_data;
      @(negedge clk);
      out_pop = 1'b0;
   endtask

   function automatic logic [31:0] in_word(input int i);
      return 32'hA000_0000 + 32'(i * 17);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      host_read(8'h18, d); check("R1 inbound status after reset", d, 32'h4000_0000);
      host_read(8'h38, d); check("R1 outbound status after reset", d, 32'h4000_0000);
      host_read(8'h1C, d); check("R1 config after reset", d, 32'h0);
      check("R1 irq after reset", {31'b0, host_irq}, 32'h0);
      check("R1 out_empty after reset", {31'b0, out_empty}, 32'h1);
   endtask

   task automatic t_inbound();
      logic [31:0] d;
      for (int i = 0; i < 8; i++) begin
         peer_push(in_word(i), 2'(i % 4));
         host_read(8'h18, d);
         check("R2 inbound status while filling", d,
               (i == 7) ? 32'h8000_0008 : 32'(i + 1));
      end
      check("R3 in_full at capacity", {31'b0, in_full}, 32'h1);
      peer_push(32'hDEAD_BEEF, 2'd3);
      host_read(8'h18, d); check("R3 push to full inbound dropped", d, 32'h8000_0008);
      host_read(8'h10, d); check("R5 peek returns oldest", d, in_word(0));
      host_read(8'h10, d); check("R5 second peek same word", d, in_word(0));
      host_read(8'h18, d); check("R5 peek leaves count", d, 32'h8000_0008);
      host_read(8'h14, d); check("R6 sender id of oldest", d, 32'd0);
      for (int i = 0; i < 8; i++) begin
         host_read(8'h14, d); check("R6 sender id while draining", d, 32'(i % 4));
         host_read(8'h00, d); check("R4 pop returns words in order", d, in_word(i));
      end
      host_read(8'h18, d); check("R4 inbound empty after draining", d, 32'h4000_0000);
      host_read(8'h00, d); check("R9 pop of empty inbound reads 0", d, 32'h0);
      host_read(8'h18, d); check("R9 empty pop leaves status", d, 32'h4000_0000);
      host_read(8'h14, d); check("R6 sender id when empty", d, 32'h0);
   endtask

   task automatic t_outbound();
      logic [31:0] d;
      for (int i = 0; i < 8; i++) host_write(8'h20, 32'h5500_0000 | 32'(i));
      host_read(8'h38, d); check("R2 outbound status full", d, 32'h8000_0008);
      host_write(8'h20, 32'hBAD0_0000);
      host_read(8'h38, d); check("R7 overflow sets sticky bit 29", d, 32'hA000_0008);
      for (int i = 0; i < 8; i++) begin
         peer_pop(d); check("R7 outbound order at peer", d, 32'h5500_0000 | 32'(i));
      end
      check("R7 out_empty after draining", {31'b0, out_empty}, 32'h1);
      peer_pop(d); check("R7 out_pop_data when empty", d, 32'h0);
      host_read(8'h38, d); check("R7 sticky overflow remains", d, 32'h6000_0000);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      host_write(8'h1C, 32'h1);
      host_read(8'h1C, d); check("R8 config readback", d, 32'h1);
      check("R8 irq low with empty inbound", {31'b0, host_irq}, 32'h0);
      peer_push(32'h1234_5678, 2'd2);
      check("R8 irq high with data", {31'b0, host_irq}, 32'h1);
      host_read(8'h00, d); check("R4 pop single word", d, 32'h1234_5678);
      check("R8 irq drops after last pop", {31'b0, host_irq}, 32'h0);
      host_write(8'h1C, 32'h0);
      peer_push(32'h0BAD_F00D, 2'd1);
      check("R8 irq masked by config", {31'b0, host_irq}, 32'h0);
      host_read(8'h00, d);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      host_read(8'h04, d); check("R10 unmapped 0x04 reads 0", d, 32'h0);
      host_read(8'h3C, d); check("R10 unmapped 0x3C reads 0", d, 32'h0);
      host_write(8'h18, 32'hFFFF_FFFF);
      host_read(8'h18, d); check("R10 write to inbound status ignored", d, 32'h4000_0000);
      host_write(8'h00, 32'h7777_7777);
      host_write(8'h10, 32'h7777_7777);
      host_read(8'h18, d); check("R10 write to pop offset ignored", d, 32'h4000_0000);
      host_read(8'h38, d); check("R10 outbound untouched", d, 32'h6000_0000);
      check("R10 out_empty untouched", {31'b0, out_empty}, 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inbound();
      t_outbound();
      t_irq();
      t_unmapped();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule